// File: doc/BRIEF.md
# SPI-Programmed Chip-Select Expander

This block turns one dedicated select line on a shared SPI bus into eight active-low device-select lines. The controller pulls the block's own select low and clocks out one byte in SPI mode 0. It then releases the select. On that release the byte becomes the new pattern on the eight select outputs. Each low bit selects one downstream device, so one byte can address a single device, any subset, all eight at once for broadcast, or none. Later bus traffic then reaches only the devices that the pattern selects.

The block's own select also gates the shift clock and floats the outputs. While the block is being programmed, its output-enable is deasserted so the select lines can rest on board pull-ups. SCLK, MOSI and the select are asynchronous to the system clock. They pass through synchronizers, and edges are detected on the synchronized copies, so the system clock must run at least four times faster than SCLK. A contention flag warns when the committed pattern selects more than one device, because those devices could then drive MISO at the same time.

Top module: `cs_expander`

## Requirements
- R1: There are eight active-low select outputs, where a 0 in bit i selects downstream device i. Any pattern can be committed, including 8'h00 (all devices) and 8'hFF (no device).
- R2: While the block's select input is high, output-enable is high. While it is low, output-enable is low, which floats the outputs. Output-enable follows a select change within four system clock cycles.
- R3: Data is shifted in only on rising SCLK edges that occur while the block's select is low. MOSI on falling SCLK edges is ignored.
- R4: Bits arrive most significant first. The first bit of a frame lands in output bit 7 and the eighth bit lands in output bit 0.
- R5: The select outputs keep their previous pattern for the whole frame. They take the new byte within four system clock cycles after the block's select rises.
- R6: SCLK and MOSI activity while the block's select is high changes neither the pending byte nor the select outputs.
- R7: When a frame carries more than eight rising SCLK edges, the last eight bits received are the ones committed.
- R8: Reset is synchronous and active high. After reset the outputs are 8'hFF, output-enable is high, the contention flag is low and the shift register holds all ones. A frame with no SCLK edges after reset therefore commits 8'hFF.
- R9: The contention flag is high exactly when the committed pattern has more than one 0 bit. It updates in the same cycle as the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCLK |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | SPI serial clock, mode 0 |
| mosi_i | input | 1 | SPI data from the controller |
| csn_i | input | 1 | The block's own active-low select |
| sel_n_o | output | 8 | Active-low device-select pattern |
| sel_oe_o | output | 1 | Output-enable for sel_n_o; low means floating |
| contention_o | output | 1 | More than one device is selected |

## Verification
The bench builds the block with its defaults: eight select lines, two synchronizer stages and a contention threshold of one low bit. It drives SCLK at one eighth of the system clock, which is twice the minimum ratio, so every edge reaches the synchronizers cleanly. That width makes the all-low broadcast pattern, the single-low patterns and the two-low contention case each take only one frame. Frames of zero, eight and twelve edges cover the empty commit, the normal commit and the overrun case. MOSI is inverted on every falling edge, which separates rising-edge sampling from falling-edge sampling.

// File: rtl/cs_exp_pkg.sv
package cs_exp_pkg;

  localparam int unsigned DEF_LINES = 8;

  typedef int unsigned cnt_t;

  // number of zero bits in a vector of up to 32 bits
  function automatic cnt_t low_count(input logic [31:0] v, input cnt_t width);
    cnt_t n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < int'(width) && !v[i]) n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/cs_exp_sync.sv
module cs_exp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);

  localparam int unsigned LEN = STAGES + 1;

  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {LEN{RST_VAL}};
    else     chain <= {chain[LEN-2:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/cs_exp_shift.sv
module cs_exp_shift #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)           q <= '1;
    else if (shift_en) q <= {q[W-2:0], din};
  end

endmodule

// File: rtl/cs_exp_outlatch.sv
module cs_exp_outlatch
  import cs_exp_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter int unsigned MAX_LOW = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  input  logic         cs_level,
  output logic [W-1:0] sel_n,
  output logic         oe,
  output logic         cont
);

  logic [31:0] d_wide;

  assign d_wide = {{(32-W){1'b1}}, d};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_n <= '1;
      oe    <= 1'b1;
      cont  <= 1'b0;
    end else begin
      oe <= cs_level;
      if (load) begin
        sel_n <= d;
        cont  <= (low_count(d_wide, W) > MAX_LOW);
      end
    end
  end

endmodule

// File: rtl/cs_expander.sv
module cs_expander
  import cs_exp_pkg::*;
#(
  parameter int unsigned LINES       = DEF_LINES,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_LOW     = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_i,
  input  logic             mosi_i,
  input  logic             csn_i,
  output logic [LINES-1:0] sel_n_o,
  output logic             sel_oe_o,
  output logic             contention_o
);

  logic sclk_lvl, sclk_rise;
  logic mosi_lvl, mosi_rise;
  logic cs_lvl, cs_rise;
  logic shift_en, commit;
  logic [LINES-1:0] shreg;

  cs_exp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst(rst), .din(sclk_i), .level(sclk_lvl), .rise(sclk_rise));

  cs_exp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst(rst), .din(mosi_i), .level(mosi_lvl), .rise(mosi_rise));

  cs_exp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst(rst), .din(csn_i), .level(cs_lvl), .rise(cs_rise));

  // gated shift clock: rising SCLK only while the block is selected
  assign shift_en = sclk_rise & ~cs_lvl;
  assign commit   = cs_rise;

  cs_exp_shift #(.W(LINES)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(mosi_lvl), .q(shreg));

  cs_exp_outlatch #(.W(LINES), .MAX_LOW(MAX_LOW)) u_latch (
    .clk(clk), .rst(rst), .load(commit), .d(shreg), .cs_level(cs_lvl),
    .sel_n(sel_n_o), .oe(sel_oe_o), .cont(contention_o));

  logic unused_ok;
  assign unused_ok = sclk_lvl ^ mosi_rise;

endmodule

// File: rtl/cs_expander_chk.sv
module cs_expander_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         commit,
  input logic [W-1:0] shreg,
  input logic [W-1:0] sel_n_o,
  input logic         sel_oe_o,
  input logic         contention_o
);

  AST_FLOAT_WHILE_LOADING: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> !sel_oe_o); // R2

  AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(shreg)); // R3

  AST_HOLD_UNTIL_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(sel_n_o)); // R5

  AST_COMMIT_TAKES_SHREG: assert property (@(posedge clk) disable iff (rst)
    commit |=> (sel_n_o == $past(shreg))); // R5

  AST_CONTENTION_FLAG: assert property (@(posedge clk) disable iff (rst)
    contention_o == ($countones(~sel_n_o) > 1)); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (sel_n_o == '1 && sel_oe_o && !contention_o)); // R8

endmodule

bind cs_expander cs_expander_chk #(.W(LINES)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .commit(commit), .shreg(shreg),
  .sel_n_o(sel_n_o), .sel_oe_o(sel_oe_o), .contention_o(contention_o));

// File: tb/cs_expander_bench.sv
module cs_expander_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic csn = 1'b1;
  logic [7:0] sel_n;
  logic oe, cont;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cs_expander u_cs_expander (
    .clk(clk), .rst(rst), .sclk_i(sclk), .mosi_i(mosi), .csn_i(csn),
    .sel_n_o(sel_n), .sel_oe_o(oe), .contention_o(cont));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one mode-0 bit; MOSI is flipped on the falling edge
  task automatic send_bit(input logic b);
    mosi = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
    mosi = ~b;
  endtask

  task automatic frame(input logic [15:0] bits, input int n, input logic [7:0] prev);
    csn = 1'b0;
    wait_clk(4);
    chk("R2 oe low while selected", {7'd0, oe}, 8'h00);
    for (int i = n - 1; i >= 0; i--) send_bit(bits[i]);
    wait_clk(4);
    chk("R5 hold during frame", sel_n, prev);
    csn = 1'b1;
    wait_clk(8);
    chk("R2 oe high after release", {7'd0, oe}, 8'h01);
  endtask

  function automatic logic [7:0] exp_cont(input logic [7:0] p);
    int z;
    z = 0;
    for (int i = 0; i < 8; i++) if (!p[i]) z++;
    return (z > 1) ? 8'h01 : 8'h00;
  endfunction

  task automatic t_reset;
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(2);
    chk("R8 reset pattern", sel_n, 8'hFF);
    chk("R8 reset oe", {7'd0, oe}, 8'h01);
    chk("R8 reset contention", {7'd0, cont}, 8'h00);
    frame(16'h0, 0, 8'hFF);
    chk("R8 empty frame after reset", sel_n, 8'hFF);
  endtask

  task automatic t_byte(input string req, input logic [7:0] v, input logic [7:0] prev);
    frame({8'h00, v}, 8, prev);
    chk(req, sel_n, v);
    chk("R9 contention", {7'd0, cont}, exp_cont(v));
  endtask

  task automatic t_idle_activity;
    for (int i = 0; i < 10; i++) begin
      mosi = i[0];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    chk("R6 outputs unchanged by idle bus", sel_n, 8'hF3);
    frame(16'h0, 0, 8'hF3);
    chk("R6 shift register unchanged by idle bus", sel_n, 8'hF3);
  endtask

  task automatic t_overrun;
    frame(16'hABC5, 12, 8'hF3);
    chk("R7 last eight bits kept", sel_n, 8'hC5);
  endtask

  initial begin
    t_reset();
    t_byte("R1 R4 single low bit 0", 8'hFE, 8'hFF);
    t_byte("R4 first bit to output 7", 8'h7F, 8'hFE);
    t_byte("R1 broadcast", 8'h00, 8'h7F);
    t_byte("R1 none selected", 8'hFF, 8'h00);
    t_byte("R3 R9 two low bits", 8'hF3, 8'hFF);
    t_idle_activity();
    t_overrun();
    t_byte("R3 alternating pattern", 8'h5A, 8'hC5);
    t_reset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule